// File: doc/BRIEF.md
# Action/Value Command Register Front End

This block is the software-facing control port of an error-record store. It has two 64-bit registers in a 16-byte window. The command register is at byte 0 and the data register is at byte 8. Software puts an argument in the data register, then writes a command code to the command register. Every effect of the block comes from that command write. Reads of either register only return its contents and change nothing.

Some commands latch the kind of operation to run. Others copy the data register into the record offset or the record identifier, or fill the data register with status, counts, limits or timing figures. The execute command hands the latched operation to a separate record engine through a request/acknowledge pair. It runs only when the data register's low byte holds the key value 0x9C. The block then holds busy until the engine answers and captures the engine's status code. The record engine and the bulk record buffer sit outside the block and are reached only through ports.

Top module: `cvr_cmd_regs`

## Requirements
- R1: The command register is at byte offset 0 and the data register at byte offset 8. A 64-bit read (`bus_dw`=1) returns the full register one cycle after `bus_rd`. Reads change no state. The command register reads back as the last low word written to offset 0, zero-extended.
- R2: A 32-bit access (`bus_dw`=0) uses the upper half of a register when address bit 2 is 1 and the lower half otherwise. A 32-bit read returns the selected half in bits 31:0 with bits 63:32 zero. A 32-bit write to the data register uses `bus_wdata[31:0]`, replaces only the selected half and keeps the other half.
- R3: A write at byte offset 4 has no effect. A command word that is not one of the listed codes has no effect. This includes any word with bits 31:8 non-zero.
- R4: Codes 0x00 (begin write), 0x01 (begin read), 0x02 (begin clear), 0x03 (end) and 0x0B (begin dummy write) only store the code as the pending operation. The pending operation is shown on `exec_op`.
- R5: Code 0x04 copies the data register into the record offset, and code 0x09 copies it into the record identifier. Both are shown on `exec_offset` and `exec_id`, and they stay unchanged while a request is pending.
- R6: Code 0x05 (execute) acts only when data bits 7:0 equal 0x9C. Other bits of the data register are ignored. With any other low byte, code 0x05 changes nothing.
- R7: If the pending operation is 0x00, 0x01 or 0x02, execute raises `exec_req` (busy) in the next cycle. The request holds until a cycle with `exec_ack`. In that cycle the status takes `exec_status`, the record identifier goes to 0 and busy clears. While busy, code 0x06 loads 1 into the data register and every other command is ignored. Code 0x06 loads 0 when idle.
- R8: If the pending operation is 0x03 or 0x0B, execute completes without a request. The status becomes 0 (success) and the record identifier returns to 0.
- R9: Code 0x07 loads the command status into the data register. Status codes are 0 success, 1 no space, 2 hardware absent, 3 failed, 4 store empty and 5 record not found.
- R10: Code 0x0A loads `store_count`, 0x0D loads `log_base`, 0x0E loads the record buffer size in bytes, 0x0F loads 0, and 0x10 loads (100 << 32) | 10, which is the maximum and minimum execute time in microseconds.
- R11: Code 0x08 loads `scan_id` into the data register and `scan_status` into the command status, and raises `scan_adv` for exactly one cycle.
- R12: After reset, the data register, command register, pending operation, record offset and record identifier are 0, busy is low and the command status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address within the window |
| bus_dw | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| exec_req | output | 1 | Request to the record engine (busy) |
| exec_op | output | 8 | Pending operation code |
| exec_offset | output | 64 | Record offset |
| exec_id | output | 64 | Record identifier |
| exec_ack | input | 1 | Engine completion |
| exec_status | input | 8 | Engine status, taken with `exec_ack` |
| scan_adv | output | 1 | One-cycle pulse to step the identifier scan |
| scan_id | input | 64 | Next identifier offered by the engine |
| scan_status | input | 8 | Status that goes with `scan_id` |
| store_count | input | 64 | Number of stored records |
| log_base | input | 64 | Base address of the record buffer |

## Verification
The assertions assume the bus never raises read and write in the same cycle. They also assume `exec_ack` comes only while a request is pending. The bench keeps to both rules: every access is a single-cycle strobe, and the engine acknowledge is given only after `exec_req` has been seen high. Random data is placed in the data register through mixed 32-bit and 64-bit writes. The execute key is then chosen on purpose, either correct in its low byte or off by one, so that both sides of the gate are exercised.

// File: rtl/cvr_pkg.sv
package cvr_pkg;
  localparam logic [7:0] CMD_BEGIN_WR  = 8'h00;
  localparam logic [7:0] CMD_BEGIN_RD  = 8'h01;
  localparam logic [7:0] CMD_BEGIN_CLR = 8'h02;
  localparam logic [7:0] CMD_END       = 8'h03;
  localparam logic [7:0] CMD_SET_OFS   = 8'h04;
  localparam logic [7:0] CMD_EXECUTE   = 8'h05;
  localparam logic [7:0] CMD_BUSY      = 8'h06;
  localparam logic [7:0] CMD_STATUS    = 8'h07;
  localparam logic [7:0] CMD_NEXT_ID   = 8'h08;
  localparam logic [7:0] CMD_SET_ID    = 8'h09;
  localparam logic [7:0] CMD_COUNT     = 8'h0A;
  localparam logic [7:0] CMD_DUMMY_WR  = 8'h0B;
  localparam logic [7:0] CMD_LOG_BASE  = 8'h0D;
  localparam logic [7:0] CMD_LOG_LEN   = 8'h0E;
  localparam logic [7:0] CMD_LOG_ATTR  = 8'h0F;
  localparam logic [7:0] CMD_TIMINGS   = 8'h10;

  localparam logic [7:0] ST_OK     = 8'd0;
  localparam logic [7:0] ST_FAILED = 8'd3;

  typedef enum logic [0:0] {EX_IDLE = 1'b0, EX_WAIT = 1'b1} cvr_ex_e;
endpackage

// File: rtl/cvr_half_merge.sv
module cvr_half_merge #(
  parameter int W = 64
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] wdata,
  input  logic         full,
  input  logic         hi,
  output logic [W-1:0] merged
);
  localparam int H = W / 2;

  always_comb begin
    if (full)    merged = wdata;
    else if (hi) merged = {wdata[H-1:0], old_val[H-1:0]};
    else         merged = {old_val[W-1:H], wdata[H-1:0]};
  end
endmodule

// File: rtl/cvr_exec_ctrl.sv
module cvr_exec_ctrl
  import cvr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack,
  output logic busy,
  output logic done
);
  cvr_ex_e st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= EX_IDLE;
    else begin
      case (st_q)
        EX_IDLE: if (start) st_q <= EX_WAIT;
        EX_WAIT: if (ack)   st_q <= EX_IDLE;
        default: st_q <= EX_IDLE;
      endcase
    end
  end

  assign busy = (st_q == EX_WAIT);
  assign done = busy && ack;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !ack |=> busy);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> !busy);
endmodule

// File: rtl/cvr_cmd_regs.sv
module cvr_cmd_regs
  import cvr_pkg::*;
#(
  parameter int          DATA_W       = 64,
  parameter int          ADDR_W       = 4,
  parameter int          STAT_W       = 8,
  parameter int          RECORD_BYTES = 8192,
  parameter int          T_MAX_US     = 100,
  parameter int          T_MIN_US     = 10,
  parameter logic [7:0]  EXEC_KEY     = 8'h9C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_dw,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              exec_req,
  output logic [7:0]        exec_op,
  output logic [DATA_W-1:0] exec_offset,
  output logic [DATA_W-1:0] exec_id,
  input  logic              exec_ack,
  input  logic [STAT_W-1:0] exec_status,
  output logic              scan_adv,
  input  logic [DATA_W-1:0] scan_id,
  input  logic [STAT_W-1:0] scan_status,
  input  logic [DATA_W-1:0] store_count,
  input  logic [DATA_W-1:0] log_base
);
  localparam int H = DATA_W / 2;
  localparam logic [DATA_W-1:0] TIMING_WORD =
    (DATA_W'(T_MAX_US) << H) | DATA_W'(T_MIN_US);
  localparam logic [DATA_W-1:0] LEN_WORD = DATA_W'(RECORD_BYTES);

  logic [DATA_W-1:0] value_q, cmd_q, offset_q, id_q, rdata_q, merged;
  logic [7:0]        op_q;
  logic [STAT_W-1:0] status_q;
  logic              adv_q, busy, done;

  logic       wr_cmd, wr_val, cmd_known, go, start, eng_op;
  logic [7:0] code;

  assign code      = bus_wdata[7:0];
  assign cmd_known = (bus_wdata[H-1:8] == '0);
  assign wr_cmd    = bus_wr && (bus_addr == '0);
  assign wr_val    = bus_wr && bus_addr[3] && (bus_addr[1:0] == 2'b00)
                     && !(bus_dw && bus_addr[2]) && (bus_addr[ADDR_W-1:4] == '0);
  assign go        = wr_cmd && cmd_known && !busy;
  assign eng_op    = (op_q == CMD_BEGIN_WR) || (op_q == CMD_BEGIN_RD) ||
                     (op_q == CMD_BEGIN_CLR);
  assign start     = go && (code == CMD_EXECUTE) &&
                     (value_q[7:0] == EXEC_KEY) && eng_op;

  cvr_half_merge #(.W(DATA_W)) u_merge (
    .old_val (value_q),
    .wdata   (bus_wdata),
    .full    (bus_dw),
    .hi      (bus_addr[2]),
    .merged  (merged)
  );

  cvr_exec_ctrl u_exec (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ack   (exec_ack),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q  <= '0;
      cmd_q    <= '0;
      offset_q <= '0;
      id_q     <= '0;
      op_q     <= CMD_BEGIN_WR;
      status_q <= ST_OK;
      rdata_q  <= '0;
      adv_q    <= 1'b0;
    end else begin
      adv_q <= 1'b0;
      if (wr_val) value_q <= merged;
      if (wr_cmd) cmd_q <= {{H{1'b0}}, bus_wdata[H-1:0]};
      if (wr_cmd && cmd_known && busy && code == CMD_BUSY)
        value_q <= {{(DATA_W-1){1'b0}}, 1'b1};
      if (go) begin
        case (code)
          CMD_BEGIN_WR, CMD_BEGIN_RD, CMD_BEGIN_CLR, CMD_END, CMD_DUMMY_WR:
            op_q <= code;
          CMD_SET_OFS: offset_q <= value_q;
          CMD_SET_ID:  id_q     <= value_q;
          CMD_EXECUTE: begin
            if (value_q[7:0] == EXEC_KEY && !eng_op) begin
              status_q <= (op_q == CMD_END || op_q == CMD_DUMMY_WR) ? ST_OK : ST_FAILED;
              id_q     <= '0;
            end
          end
          CMD_BUSY:     value_q <= '0;
          CMD_STATUS:   value_q <= DATA_W'(status_q);
          CMD_NEXT_ID: begin
            value_q  <= scan_id;
            status_q <= scan_status;
            adv_q    <= 1'b1;
          end
          CMD_COUNT:    value_q <= store_count;
          CMD_LOG_BASE: value_q <= log_base;
          CMD_LOG_LEN:  value_q <= LEN_WORD;
          CMD_LOG_ATTR: value_q <= '0;
          CMD_TIMINGS:  value_q <= TIMING_WORD;
          default: ;
        endcase
      end
      if (done) begin
        status_q <= exec_status;
        id_q     <= '0;
      end
      if (bus_rd) begin
        if (bus_dw)
          rdata_q <= bus_addr[3] ? value_q : cmd_q;
        else if (bus_addr[2])
          rdata_q <= {{H{1'b0}}, (bus_addr[3] ? value_q[DATA_W-1:H] : cmd_q[DATA_W-1:H])};
        else
          rdata_q <= {{H{1'b0}}, (bus_addr[3] ? value_q[H-1:0] : cmd_q[H-1:0])};
      end
    end
  end

  assign bus_rdata   = rdata_q;
  assign exec_req    = busy;
  assign exec_op     = op_q;
  assign exec_offset = offset_q;
  assign exec_id     = id_q;
  assign scan_adv    = adv_q;

  // R6
  exec_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(exec_req) |-> $past(wr_cmd && value_q[7:0] == EXEC_KEY));
  // R7
  id_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(exec_req) |-> exec_id == '0);
  // R1
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !bus_wr |=> $stable(value_q) && $stable(op_q) && $stable(status_q));
  // R5
  req_args_chk: assert property (@(posedge clk) disable iff (rst)
    exec_req && $past(exec_req) |-> $stable(exec_offset) && $stable(exec_id) && $stable(exec_op));
  // R11
  adv_src_chk: assert property (@(posedge clk) disable iff (rst)
    scan_adv |-> $past(wr_cmd && bus_wdata[H-1:0] == H'(CMD_NEXT_ID) && !busy));
endmodule

// File: tb/cvr_cmd_regs_tb.sv
`timescale 1ns/1ps
module cvr_cmd_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_dw = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        exec_req, exec_ack = 1'b0, scan_adv;
  logic [7:0]  exec_op, exec_status = '0, scan_status = '0;
  logic [63:0] exec_offset, exec_id;
  logic [63:0] scan_id = '0, store_count = '0, log_base = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cvr_cmd_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_dw(bus_dw), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .exec_req(exec_req), .exec_op(exec_op),
    .exec_offset(exec_offset), .exec_id(exec_id), .exec_ack(exec_ack),
    .exec_status(exec_status), .scan_adv(scan_adv), .scan_id(scan_id),
    .scan_status(scan_status), .store_count(store_count), .log_base(log_base)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic dw, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_dw = dw; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic dw, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_dw = dw;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic cmd(input logic [31:0] c);
    wr(4'h0, 1'b0, {32'h0, c});
  endtask

  task automatic setv(input logic [63:0] v);
    wr(4'h8, 1'b1, v);
  endtask

  task automatic ack(input logic [7:0] s);
    @(negedge clk);
    exec_ack = 1'b1; exec_status = s;
    @(negedge clk);
    exec_ack = 1'b0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] merge_exp(input logic [63:0] o, input logic [31:0] w, input logic hi);
    return hi ? {w, o[31:0]} : {o[63:32], w};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r, v, e;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    rd(4'h8, 1'b1, r); check("R12 value", r, 64'h0);
    rd(4'h0, 1'b1, r); check("R12 cmd", r, 64'h0);
    check("R12 busy", {63'h0, exec_req}, 64'h0);
    check("R12 op", {56'h0, exec_op}, 64'h0);
    check("R12 offset", exec_offset, 64'h0);
    check("R12 id", exec_id, 64'h0);
    cmd(32'h7); rd(4'h8, 1'b1, r); check("R12 status", r, 64'h0);

    // R1 / R2 random register traffic
    for (int i = 0; i < 20; i++) begin
      v = rnd64();
      setv(v);
      rd(4'h8, 1'b1, r); check("R1 value 64", r, v);
      rd(4'h8, 1'b1, r); check("R1 read no side effect", r, v);
      rd(4'hC, 1'b0, r); check("R2 read hi", r, {32'h0, v[63:32]});
      rd(4'h8, 1'b0, r); check("R2 read lo", r, {32'h0, v[31:0]});
      e = rnd64();
      wr(((i % 2) != 0) ? 4'hC : 4'h8, 1'b0, e);
      v = merge_exp(v, e[31:0], (i % 2) != 0);
      rd(4'h8, 1'b1, r); check("R2 merge", r, v);
    end
    cmd(32'h0000_0009);
    rd(4'h0, 1'b1, r); check("R1 cmd readback", r, 64'h9);

    // R3 ignored write and unknown codes
    v = 64'h1122_3344_5566_7788;
    setv(v);
    wr(4'h4, 1'b0, 64'h0A);
    rd(4'h8, 1'b1, r); check("R3 offset4 ignored", r, v);
    cmd(32'h0C);  rd(4'h8, 1'b1, r); check("R3 code 0C", r, v);
    cmd(32'h11);  rd(4'h8, 1'b1, r); check("R3 code 11", r, v);
    cmd(32'h10E); rd(4'h8, 1'b1, r); check("R3 code 10E", r, v);
    check("R3 op untouched", {56'h0, exec_op}, 64'h0);

    // R10 loaders
    store_count = rnd64(); log_base = rnd64();
    cmd(32'h0E); rd(4'h8, 1'b1, r); check("R10 length", r, 64'd8192);
    cmd(32'h0F); rd(4'h8, 1'b1, r); check("R10 attr", r, 64'h0);
    cmd(32'h10); rd(4'h8, 1'b1, r); check("R10 timings", r, (64'd100 << 32) | 64'd10);
    cmd(32'h0A); rd(4'h8, 1'b1, r); check("R10 count", r, store_count);
    cmd(32'h0D); rd(4'h8, 1'b1, r); check("R10 base", r, log_base);

    // R11 scan step
    scan_id = 64'hABCD_0000_1234; scan_status = 8'd4;
    cmd(32'h08);
    check("R11 adv pulse", {63'h0, scan_adv}, 64'h1);
    @(negedge clk);
    check("R11 adv one cycle", {63'h0, scan_adv}, 64'h0);
    rd(4'h8, 1'b1, r); check("R11 id", r, scan_id);
    cmd(32'h07); rd(4'h8, 1'b1, r); check("R11 R9 status", r, 64'd4);

    // R4 R5 R7 engine operation
    cmd(32'h01);
    check("R4 op read", {56'h0, exec_op}, 64'h01);
    setv(64'h40); cmd(32'h04);
    setv(64'h1234_5678_9ABC); cmd(32'h09);
    check("R5 offset", exec_offset, 64'h40);
    check("R5 id", exec_id, 64'h1234_5678_9ABC);
    setv(64'hFF00_009C);
    cmd(32'h05);
    check("R7 req raised", {63'h0, exec_req}, 64'h1);
    cmd(32'h06); rd(4'h8, 1'b1, r); check("R7 busy reads 1", r, 64'h1);
    cmd(32'h07); rd(4'h8, 1'b1, r); check("R7 ignored while busy", r, 64'h1);
    cmd(32'h02); check("R7 op kept while busy", {56'h0, exec_op}, 64'h01);
    repeat (4) @(negedge clk);
    check("R7 req held", {63'h0, exec_req}, 64'h1);
    check("R5 id held", exec_id, 64'h1234_5678_9ABC);
    ack(8'd5);
    check("R7 req dropped", {63'h0, exec_req}, 64'h0);
    check("R7 id cleared", exec_id, 64'h0);
    cmd(32'h07); rd(4'h8, 1'b1, r); check("R9 status 5", r, 64'd5);
    cmd(32'h06); rd(4'h8, 1'b1, r); check("R7 idle busy 0", r, 64'h0);

    // R6 wrong key
    cmd(32'h02);
    setv(64'h9D);
    cmd(32'h05);
    check("R6 no req", {63'h0, exec_req}, 64'h0);
    cmd(32'h07); rd(4'h8, 1'b1, r); check("R6 status kept", r, 64'd5);
    setv(64'h9C_9C00);
    cmd(32'h05);
    check("R6 key in byte1 ignored", {63'h0, exec_req}, 64'h0);
    setv(64'h9C);
    cmd(32'h05);
    check("R6 key ok", {63'h0, exec_req}, 64'h1);
    ack(8'd2);
    cmd(32'h07); rd(4'h8, 1'b1, r); check("R9 status 2", r, 64'd2);

    // R8 end and dummy write
    setv(64'h55); cmd(32'h09);
    cmd(32'h03);
    setv(64'h9C); cmd(32'h05);
    check("R8 end no req", {63'h0, exec_req}, 64'h0);
    check("R8 id cleared", exec_id, 64'h0);
    cmd(32'h07); rd(4'h8, 1'b1, r); check("R8 end status", r, 64'd0);
    scan_status = 8'd1; cmd(32'h08);
    cmd(32'h0B);
    check("R4 dummy op", {56'h0, exec_op}, 64'h0B);
    setv(64'h9C); cmd(32'h05);
    check("R8 dummy no req", {63'h0, exec_req}, 64'h0);
    cmd(32'h07); rd(4'h8, 1'b1, r); check("R8 dummy status", r, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule